// File: doc/BRIEF.md
# Supervisor Fault and Ready Logic

This block is the digital side of a two-channel voltage supervisor. Each channel receives a comparator bit, which is high while the monitored voltage sits above its threshold. Configuration picks, for each channel, whether a low bit (under-voltage) or a high bit (over-voltage) counts as a fault. A fault has to persist for a set number of clocks before it is recognised. Any recognised fault drives the open-drain fault pin low. That drive can be held off while output margining is in progress.

A separate regulation-status input shows whether the sensed output is at its set point. The block reflects that status on a ready pin whose polarity is configurable. When the ready pin is configured active high, it doubles as an input. An external device that pulls it low, while the block itself is releasing it, freezes the comparator samples. The fault logic then works from the frozen values until the pin rises again.

Both open-drain pins appear as drive-low enables. The ready pin's actual level comes back through its own input port.

Top module: `supv_fault_ready`

## Requirements
- R1: `cfg_ov[i]`=1 makes channel i a fault when its comparator bit is 1 (over-voltage). `cfg_ov[i]`=0 makes it a fault when the bit is 0 (under-voltage).
- R2: A channel condition is recognised only after it has held for QUAL_CYC (default 4) consecutive clocks. With defaults, a condition applied before a clock edge raises `fault_drive_low` at the 8th edge: 2 synchroniser stages, 1 sample register, 4 qualification counts and 1 output register. A condition lasting 3 sampled clocks never raises it.
- R3: `fault_drive_low` is the OR of all qualified channels.
- R4: Fault indication is level-driven and never sticky. With defaults, `fault_drive_low` falls at the 5th edge after the comparator leaves the fault state.
- R5: A channel whose `cfg_ch_en` bit is 0 never contributes a fault.
- R6: When `cfg_mask_marg`=1 and `marg_active`=1, `fault_drive_low` is 0 from the next edge. When either is 0, margining has no effect.
- R7: When `cfg_rdy_high`=1, `rdy_drive_low` equals the inverse of `reg_ok`. When `cfg_rdy_high`=0, it equals `reg_ok`. The output takes the new value one edge after the input changes.
- R8: `latch_active`=1 when `cfg_rdy_high`=1, `rdy_drive_low`=0 and `rdy_pin_in`=0. While it is 1, `cmp_state` holds its value and faults are judged on the held values.
- R9: When `rdy_pin_in` returns high, live sampling resumes. When `cfg_rdy_high`=0, a low `rdy_pin_in` is ignored. A low pin that the block itself drives (`rdy_drive_low`=1) does not freeze the samples either.
- R10: During reset, `fault_drive_low`, `rdy_drive_low` and `cmp_state` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_in | input | NCH | Raw comparator bits, 1 = above threshold |
| cfg_ov | input | NCH | Per-channel mode, 1 = over-voltage, 0 = under-voltage |
| cfg_ch_en | input | NCH | Per-channel fault enable |
| reg_ok | input | 1 | Sensed output is at its set point |
| cfg_rdy_high | input | 1 | Ready pin polarity, 1 = active high |
| rdy_pin_in | input | 1 | Synchronous read-back of the ready pin level |
| marg_active | input | 1 | Margining in progress |
| cfg_mask_marg | input | 1 | Suppress the fault pin during margining |
| fault_drive_low | output | 1 | Pull the fault pin low |
| rdy_drive_low | output | 1 | Pull the ready pin low |
| latch_active | output | 1 | Comparator samples are frozen |
| cmp_state | output | NCH | Comparator sample used by the fault logic |

## Verification
The assertions assume that `reg_ok`, `rdy_pin_in`, `marg_active` and all configuration bits are already synchronous to `clk`. Only `cmp_in` may be asynchronous. The stimulus changes every input on the falling edge, so each value is steady across the rising edge that samples it. Configuration changes happen only during settle windows longer than the 8-edge path. That way no check straddles a change of polarity or enable.

// File: rtl/supv_pkg.sv
package supv_pkg;
   typedef enum logic {
      MODE_UV = 1'b0,
      MODE_OV = 1'b1
   } chan_mode_e;

   // comparator bit is 1 when the voltage is above its threshold
   function automatic logic chan_fault(chan_mode_e mode, logic cmp);
      return (mode == MODE_OV) ? cmp : ~cmp;
   endfunction
endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("supv_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("supv_sync: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/supv_chan_qual.sv
module supv_chan_qual
   import supv_pkg::*;
#(
   parameter int QUAL_CYC = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  chan_mode_e mode,
   input  logic       cmp,
   output logic       qual
);
   generate
      if (QUAL_CYC < 1) begin : g_bad_qual
         $error("supv_chan_qual: QUAL_CYC must be at least 1");
      end
   endgenerate

   localparam int CW = $clog2(QUAL_CYC + 1);
   localparam logic [CW-1:0] CMAX = CW'(QUAL_CYC);

   logic          raw;
   logic [CW-1:0] cnt;

   assign raw = en & chan_fault(mode, cmp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (!raw)        cnt <= '0;
      else if (cnt != CMAX) cnt <= cnt + 1'b1;
   end

   assign qual = (cnt == CMAX);

   // R4: a vanished condition clears the run at once
   p_run_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !raw |=> (cnt == '0) && !qual);
   // R5: a disabled channel never qualifies
   p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !qual);
   // R2: qualification is reached only from a run that was in progress
   p_qual_needs_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(qual) |-> $past(raw));
endmodule

// File: rtl/supv_fault_ready.sv
module supv_fault_ready
   import supv_pkg::*;
#(
   parameter int NCH         = 2,
   parameter int SYNC_STAGES = 2,
   parameter int QUAL_CYC    = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] cmp_in,
   input  logic [NCH-1:0] cfg_ov,
   input  logic [NCH-1:0] cfg_ch_en,
   input  logic           reg_ok,
   input  logic           cfg_rdy_high,
   input  logic           rdy_pin_in,
   input  logic           marg_active,
   input  logic           cfg_mask_marg,
   output logic           fault_drive_low,
   output logic           rdy_drive_low,
   output logic           latch_active,
   output logic [NCH-1:0] cmp_state
);
   generate
      if (NCH < 1 || NCH > 32) begin : g_bad_nch
         $error("supv_fault_ready: NCH out of range");
      end
   endgenerate

   logic [NCH-1:0] cmp_s;
   logic [NCH-1:0] qual_v;
   logic           suppress;

   supv_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (cmp_in),
      .q     (cmp_s)
   );

   // an external low only counts when the block is not pulling low itself
   assign latch_active = cfg_rdy_high & ~rdy_drive_low & ~rdy_pin_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cmp_state <= '0;
      else if (!latch_active) cmp_state <= cmp_s;
   end

   for (genvar i = 0; i < NCH; i++) begin : g_chan
      supv_chan_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (cfg_ch_en[i]),
         .mode  (chan_mode_e'(cfg_ov[i])),
         .cmp   (cmp_state[i]),
         .qual  (qual_v[i])
      );
   end

   assign suppress = cfg_mask_marg & marg_active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_drive_low <= 1'b0;
         rdy_drive_low   <= 1'b0;
      end else begin
         fault_drive_low <= (|qual_v) & ~suppress;
         rdy_drive_low   <= cfg_rdy_high ? ~reg_ok : reg_ok;
      end
   end

   // R6: margining with the mask set keeps the fault pin released
   p_margin_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mask_marg && marg_active) |=> !fault_drive_low);
   // R8: frozen samples do not move
   p_hold_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      latch_active |=> $stable(cmp_state));
   // R7: ready follows regulation status with the chosen polarity
   p_ready_pol_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdy_high && reg_ok) |=> !rdy_drive_low);
   // R3: no qualified channel means the fault pin is released next
   p_fault_or_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (qual_v == '0) |=> !fault_drive_low);
endmodule

// File: tb/supv_fault_ready_bench.sv
module supv_fault_ready_bench;
   localparam int NCH = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] cmp_in = '0, cfg_ov = '0, cfg_ch_en = '0, cmp_state;
   logic           reg_ok = 1'b0, cfg_rdy_high = 1'b0, rdy_pin_in = 1'b1;
   logic           marg_active = 1'b0, cfg_mask_marg = 1'b0;
   logic           fault_drive_low, rdy_drive_low, latch_active;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   supv_fault_ready u_supv_fault_ready (
      .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .cfg_ov(cfg_ov),
      .cfg_ch_en(cfg_ch_en), .reg_ok(reg_ok), .cfg_rdy_high(cfg_rdy_high),
      .rdy_pin_in(rdy_pin_in), .marg_active(marg_active),
      .cfg_mask_marg(cfg_mask_marg), .fault_drive_low(fault_drive_low),
      .rdy_drive_low(rdy_drive_low), .latch_active(latch_active),
      .cmp_state(cmp_state)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic exp_fault(logic [NCH-1:0] ov, logic [NCH-1:0] en, logic [NCH-1:0] c);
      logic f = 1'b0;
      for (int i = 0; i < NCH; i++)
         f |= en[i] & (ov[i] ? c[i] : ~c[i]);
      return f;
   endfunction

   initial begin
      #200000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      step(3);
      // R10: reset state
      chk("R10 fault", fault_drive_low, 0);
      chk("R10 ready", rdy_drive_low, 0);
      chk("R10 state", cmp_state, 0);
      rst_n = 1'b1;

      // R1 R3 R5: exhaustive over mode, enable and comparator pattern
      for (int ov = 0; ov < 4; ov++)
         for (int en = 0; en < 4; en++)
            for (int c = 0; c < 4; c++) begin
               cfg_ov = ov[1:0]; cfg_ch_en = en[1:0]; cmp_in = c[1:0];
               step(10);
               chk("R1/R3/R5 sweep", fault_drive_low,
                   exp_fault(ov[1:0], en[1:0], c[1:0]));
            end

      // R2 exact latency: channel 0 UV, leaves healthy level
      cfg_ov = 2'b00; cfg_ch_en = 2'b01; cmp_in = 2'b01;
      step(10);
      cmp_in = 2'b00;
      step(7);
      chk("R2 before 8th edge", fault_drive_low, 0);
      step(1);
      chk("R2 at 8th edge", fault_drive_low, 1);
      // R4 release timing
      cmp_in = 2'b01;
      step(4);
      chk("R4 still set at 4th edge", fault_drive_low, 1);
      step(1);
      chk("R4 cleared at 5th edge", fault_drive_low, 0);

      // R2 short glitch of 3 clocks is ignored
      step(5);
      cmp_in = 2'b00;
      step(3);
      cmp_in = 2'b01;
      begin
         logic seen = 1'b0;
         for (int k = 0; k < 15; k++) begin
            step(1);
            seen |= fault_drive_low;
         end
         chk("R2 glitch ignored", seen, 0);
      end

      // R6: margining mask
      cfg_ov = 2'b10; cfg_ch_en = 2'b10; cmp_in = 2'b10;
      for (int m = 0; m < 4; m++) begin
         cfg_mask_marg = m[0]; marg_active = m[1];
         step(10);
         chk("R6 mask", fault_drive_low, !(m[0] && m[1]));
      end
      cfg_mask_marg = 1'b0; marg_active = 1'b0;

      // R7: ready polarity sweep
      for (int p = 0; p < 4; p++) begin
         cfg_rdy_high = p[0]; reg_ok = p[1];
         step(1);
         chk("R7 ready", rdy_drive_low, p[0] ? !p[1] : p[1]);
      end

      // R8: external low freezes samples
      cfg_rdy_high = 1'b1; reg_ok = 1'b1; rdy_pin_in = 1'b1;
      cfg_ov = 2'b00; cfg_ch_en = 2'b11; cmp_in = 2'b11;
      step(10);
      chk("R8 setup no fault", fault_drive_low, 0);
      rdy_pin_in = 1'b0;
      cmp_in = 2'b00;
      #1;
      chk("R8 latch flag", latch_active, 1);
      step(12);
      chk("R8 frozen state", cmp_state, 2'b11);
      chk("R8 fault on frozen", fault_drive_low, 0);
      // R9: release resumes live sampling
      rdy_pin_in = 1'b1;
      step(12);
      chk("R9 resume state", cmp_state, 2'b00);
      chk("R9 resume fault", fault_drive_low, 1);

      // R9: self-driven low does not freeze
      reg_ok = 1'b0; rdy_pin_in = 1'b0;
      step(2);
      chk("R9 self drive flag", latch_active, 0);
      cmp_in = 2'b11;
      step(5);
      chk("R9 self drive sampling", cmp_state, 2'b11);

      // R9: active-low polarity ignores a low pin
      cfg_rdy_high = 1'b0; reg_ok = 1'b0; rdy_pin_in = 1'b0;
      step(2);
      chk("R9 activelow flag", latch_active, 0);
      cmp_in = 2'b01;
      step(5);
      chk("R9 activelow sampling", cmp_state, 2'b01);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule